// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a CPU core and an asynchronous external memory. It runs byte-wide read and write cycles over a bus whose eight low lines carry first the low address byte, marked by an address latch enable strobe, and then the data byte. A separate eight-bit bus carries the high address byte for the whole access. Active-low read and write strobes frame the data phase.

The 64 KiB external space is split at a programmable boundary into a lower and an upper sector. Each sector has its own 2-bit wait-state code, so a fast and a slow device can share the bus. When the next request is already waiting during the final period of an access, the latch strobe for that request is issued in that same period and the new access goes straight to its data phase. An optional bus keeper holds the last value driven on the shared lines while the controller is not driving them.

The core side is a valid/ready request channel with a response pulse. A request holds `req_valid` and its fields steady until the cycle in which `req_ready` is also high; that cycle is the transfer. `req_ready` is high only in the idle state and in the final period of an access, so the controller applies back-pressure for the rest of each access. The response has no back-pressure: `rsp_valid` is a one-cycle pulse that the core must take when it comes.

Top module: `xmem_ctrl`

## Requirements
- R1: `req_ready` is high only in idle and in the final period (T4) of an access. A request is transferred on a clock edge with both `req_valid` and `req_ready` high. `req_ready` is low from the latch-enable cycle until T4.
- R2: With a wait code of 00, an access taken from idle has these periods: one cycle with `xale` high (T1), two read- or write-strobe cycles (T2, T3), then T4. `rsp_valid` is high in T4.
- R3: Strobe length by wait code: 00 gives 2 cycles, 01 gives 3, 10 gives 4 and 11 gives 4. Code 11 also inserts one extra cycle, with `xale` low and `req_ready` low, between the end of the strobe and T4.
- R4: The sector is chosen from `req_addr[15:13]`. A value at or above `cfg_bound` uses `cfg_ws_hi`, and any lower value uses `cfg_ws_lo`.
- R5: While `xale` is high, `xad_out` carries the low address byte with `xad_oe` high, and both strobes are high. `xa_hi` carries address bits 15:8 from the latch-enable cycle to the end of the strobe.
- R6: On a write, `xwr_n` is low for the strobe cycles. `xad_out` carries the write byte with `xad_oe` high from the cycle after `xale` falls through the last cycle in which `xwr_n` is low. `xrd_n` stays high.
- R7: On a read, `xrd_n` is low for the strobe cycles with `xad_oe` low. `xad_in` is sampled on the clock edge that ends the last strobe cycle. The sampled byte is returned on `rsp_rdata` while `rsp_valid` is high.
- R8: In T4, `xale` is high, and the new low address byte is on `xad_out`, only while `req_valid` is high. A request taken in T4 starts its strobe in the next cycle. With no request, `xale` stays low in T4 and the controller returns to idle.
- R9: While `xad_oe` is low and `cfg_keep_en` is 1, `xad_keep` is 1 and `xad_out` holds the last byte driven with `xad_oe` high. While `cfg_keep_en` is 0, `xad_keep` is 0.
- R10: `rsp_valid` is high for exactly one cycle per access, in the cycle right after the strobe ends.
- R11: After reset, the controller is idle: `req_ready` is 1, `xale` is 0, `xrd_n` and `xwr_n` are 1, `xad_oe` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte |
| cfg_bound | input | 3 | Lowest address-top value of the upper sector |
| cfg_ws_lo | input | 2 | Wait code, lower sector |
| cfg_ws_hi | input | 2 | Wait code, upper sector |
| cfg_keep_en | input | 1 | Bus keeper enable |
| xad_in | input | 8 | Shared address/data lines, input side |
| xad_out | output | 8 | Shared address/data lines, output value |
| xad_oe | output | 1 | Strong drive enable for xad_out |
| xad_keep | output | 1 | Weak hold of xad_out by the keeper |
| xale | output | 1 | Address latch enable, active high |
| xa_hi | output | 8 | High address byte |
| xrd_n | output | 1 | Read strobe, active low |
| xwr_n | output | 1 | Write strobe, active low |

## Verification
A wrong strobe counter or a wrong latched wait code shows up at once as a strobe that is one or more cycles too long or too short. In the same access, `rsp_valid` then moves to the wrong cycle. A sequencer stuck outside idle holds `req_ready` low and leaves the next request waiting. A bad address or data register shows up on `xad_out` or `xa_hi` in the latch-enable or strobe cycle of the access that uses it. A keeper that does not hold its value shows up as a change on `xad_out` in the first idle cycle after a write.

// File: rtl/xmem_pkg.sv
`timescale 1ns/1ps
package xmem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_HOLD,
    ST_T4
  } xm_state_e;

  // Strobe length in cycles for a 2-bit wait code.
  function automatic logic [2:0] strobe_len(input logic [1:0] code);
    case (code)
      2'b00:   strobe_len = 3'd2;
      2'b01:   strobe_len = 3'd3;
      default: strobe_len = 3'd4;
    endcase
  endfunction

  // Code 11 adds a quiet cycle before the next address phase.
  function automatic logic has_hold(input logic [1:0] code);
    has_hold = (code == 2'b11);
  endfunction

endpackage

// File: rtl/xmem_sector.sv
`timescale 1ns/1ps
module xmem_sector #(
  parameter int BOUND_W = 3
) (
  input  logic [BOUND_W-1:0] addr_top,
  input  logic [BOUND_W-1:0] bound,
  input  logic [1:0]         ws_lo,
  input  logic [1:0]         ws_hi,
  output logic [1:0]         ws_code
);
  always_comb begin
    ws_code = (addr_top >= bound) ? ws_hi : ws_lo;
  end
endmodule

// File: rtl/xmem_seq.sv
`timescale 1ns/1ps
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        ws_code,
  input  logic [DATA_W-1:0] xad_in,
  output logic              req_ready,
  output xm_state_e         state,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              wr_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [2:0] len_q;
  logic [2:0] cnt;
  logic       hold_q;
  logic       accept;

  always_comb begin
    req_ready = (state == ST_IDLE) || (state == ST_T4);
    accept    = req_valid && req_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      wr_q      <= 1'b0;
      len_q     <= 3'd2;
      hold_q    <= 1'b0;
      cnt       <= 3'd0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) state <= ST_ADDR;
        ST_ADDR: begin
          state <= ST_STRB;
          cnt   <= 3'd1;
        end
        ST_STRB: begin
          if (cnt == len_q) begin
            rsp_valid <= 1'b1;
            if (!wr_q) rsp_rdata <= xad_in;
            state <= hold_q ? ST_HOLD : ST_T4;
          end else begin
            cnt <= cnt + 3'd1;
          end
        end
        ST_HOLD: state <= ST_T4;
        ST_T4: begin
          if (req_valid) begin
            state <= ST_STRB;
            cnt   <= 3'd1;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
        len_q   <= strobe_len(ws_code);
        hold_q  <= has_hold(ws_code);
      end
    end
  end
endmodule

// File: rtl/xmem_bus.sv
`timescale 1ns/1ps
module xmem_bus
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xm_state_e         state,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              wr_q,
  input  logic              keep_en,
  output logic              xale,
  output logic [ADDR_W-DATA_W-1:0] xa_hi,
  output logic [DATA_W-1:0] xad_out,
  output logic              xad_oe,
  output logic              xad_keep,
  output logic              xrd_n,
  output logic              xwr_n
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] last_q;
  logic              early_ale;

  always_comb begin
    early_ale = (state == ST_T4) && req_valid;
    xale      = (state == ST_ADDR) || early_ale;
    xa_hi     = early_ale ? req_addr[ADDR_W-1 -: HI_W] : addr_q[ADDR_W-1 -: HI_W];
    xrd_n     = !((state == ST_STRB) && !wr_q);
    xwr_n     = !((state == ST_STRB) && wr_q);
    xad_oe    = 1'b1;
    if (state == ST_ADDR)                  xad_out = addr_q[DATA_W-1:0];
    else if (early_ale)                    xad_out = req_addr[DATA_W-1:0];
    else if ((state == ST_STRB) && wr_q)   xad_out = wdata_q;
    else begin
      xad_out = last_q;
      xad_oe  = 1'b0;
    end
    xad_keep  = keep_en && !xad_oe;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= '0;
    else if (xad_oe) last_q <= xad_out;
  end
endmodule

// File: rtl/xmem_ctrl.sv
`timescale 1ns/1ps
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int BOUND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [BOUND_W-1:0] cfg_bound,
  input  logic [1:0]        cfg_ws_lo,
  input  logic [1:0]        cfg_ws_hi,
  input  logic              cfg_keep_en,
  input  logic [DATA_W-1:0] xad_in,
  output logic [DATA_W-1:0] xad_out,
  output logic              xad_oe,
  output logic              xad_keep,
  output logic              xale,
  output logic [ADDR_W-DATA_W-1:0] xa_hi,
  output logic              xrd_n,
  output logic              xwr_n
);
  logic [1:0]        ws_code;
  xm_state_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;

  xmem_sector #(.BOUND_W(BOUND_W)) u_sector (
    .addr_top (req_addr[ADDR_W-1 -: BOUND_W]),
    .bound    (cfg_bound),
    .ws_lo    (cfg_ws_lo),
    .ws_hi    (cfg_ws_hi),
    .ws_code  (ws_code)
  );

  xmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ws_code   (ws_code),
    .xad_in    (xad_in),
    .req_ready (req_ready),
    .state     (state),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .wr_q      (wr_q),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  xmem_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .wr_q      (wr_q),
    .keep_en   (cfg_keep_en),
    .xale      (xale),
    .xa_hi     (xa_hi),
    .xad_out   (xad_out),
    .xad_oe    (xad_oe),
    .xad_keep  (xad_keep),
    .xrd_n     (xrd_n),
    .xwr_n     (xwr_n)
  );
endmodule

// File: rtl/xmem_ctrl_chk.sv
`timescale 1ns/1ps
module xmem_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic [DATA_W-1:0]        xad_out,
  input logic                     xad_oe,
  input logic                     xad_keep,
  input logic                     xale,
  input logic [ADDR_W-DATA_W-1:0] xa_hi,
  input logic                     xrd_n,
  input logic                     xwr_n
);
  assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (xrd_n && xwr_n));

  assert_rsp_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (xrd_n && xwr_n && ($past(!xrd_n) || $past(!xwr_n))));

  assert_ale_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xale |-> (xrd_n && xwr_n && xad_oe));

  assert_hi_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(xrd_n && xwr_n) && $past(!(xrd_n && xwr_n))) |-> $stable(xa_hi));

  assert_wr_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !xwr_n |-> (xad_oe && xrd_n));

  assert_rd_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xrd_n |-> !xad_oe);

  assert_keeper_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xad_keep && $past(xad_keep)) |-> $stable(xad_out));

  assert_rsp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind xmem_ctrl xmem_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .xad_out   (xad_out),
  .xad_oe    (xad_oe),
  .xad_keep  (xad_keep),
  .xale      (xale),
  .xa_hi     (xa_hi),
  .xrd_n     (xrd_n),
  .xwr_n     (xwr_n)
);

// File: tb/test_xmem_ctrl.sv
`timescale 1ns/1ps
module test_xmem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [2:0]  cfg_bound = 3'd0;
  logic [1:0]  cfg_ws_lo = 2'b00;
  logic [1:0]  cfg_ws_hi = 2'b00;
  logic        cfg_keep_en = 1'b0;
  logic [7:0]  xad_in;
  logic [7:0]  xad_out;
  logic        xad_oe, xad_keep, xale, xrd_n, xwr_n;
  logic [7:0]  xa_hi;
  logic [7:0]  mem_byte = 8'h00;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  // Memory model: drives its byte only while the read strobe is low.
  assign xad_in = !xrd_n ? mem_byte : 8'hC3;

  xmem_ctrl i_xmem_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_bound(cfg_bound),
    .cfg_ws_lo(cfg_ws_lo), .cfg_ws_hi(cfg_ws_hi), .cfg_keep_en(cfg_keep_en),
    .xad_in(xad_in), .xad_out(xad_out), .xad_oe(xad_oe), .xad_keep(xad_keep),
    .xale(xale), .xa_hi(xa_hi), .xrd_n(xrd_n), .xwr_n(xwr_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access from idle; checks every period against the requirements.
  task automatic run_access(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                            input logic [7:0] rd, input int exp_len, input bit exp_hold);
    int n;
    @(negedge clk);
    req_write = wr; req_addr = addr; req_wdata = wd; mem_byte = rd; req_valid = 1'b1;
    #0.1 check(req_ready == 1'b1, "R1 ready in idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(xale == 1'b1, "R5 ale high", xale, 1);
    check(xad_oe && xad_out == addr[7:0], "R5 low addr on bus", xad_out, addr[7:0]);
    check(xa_hi == addr[15:8], "R5 high addr", xa_hi, addr[15:8]);
    check(req_ready == 1'b0, "R1 back-pressure", req_ready, 0);
    n = 0;
    @(negedge clk);
    while ((wr ? !xwr_n : !xrd_n) && n < 12) begin
      n++;
      check(xa_hi == addr[15:8], "R5 high addr in strobe", xa_hi, addr[15:8]);
      if (wr) check(xad_oe && xad_out == wd && xrd_n, "R6 write data", xad_out, wd);
      else    check(!xad_oe && xwr_n, "R7 bus released", xad_oe, 0);
      @(negedge clk);
    end
    check(n == exp_len, "R3 strobe length", n, exp_len);
    check(rsp_valid == 1'b1, "R10 rsp pulse", rsp_valid, 1);
    check(xrd_n && xwr_n, "R2 strobes end", {xrd_n, xwr_n}, 3);
    if (!wr) check(rsp_rdata == rd, "R7 read data", rsp_rdata, rd);
    if (exp_hold) begin
      check(!req_ready && !xale, "R3 hold cycle quiet", {req_ready, xale}, 0);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R10 single pulse", rsp_valid, 0);
    end
    check(req_ready == 1'b1, "R1 ready in T4", req_ready, 1);
    check(xale == 1'b0, "R8 no ale without request", xale, 0);
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready, "R10 idle after access", rsp_valid, 0);
  endtask

  task automatic test_reset();
    check(req_ready && !xale && xrd_n && xwr_n && !xad_oe && !rsp_valid,
          "R11 reset state", {req_ready, xale, xrd_n, xwr_n, xad_oe, rsp_valid}, 6'b101100);
  endtask

  task automatic test_zero_wait();
    cfg_bound = 3'd0; cfg_ws_lo = 2'b00; cfg_ws_hi = 2'b00;
    run_access(1'b1, 16'h12A5, 8'h3C, 8'h00, 2, 1'b0);   // R2 write
    run_access(1'b0, 16'h8001, 8'h00, 8'h96, 2, 1'b0);   // R2 read
  endtask

  task automatic test_codes();
    cfg_bound = 3'd0;
    cfg_ws_hi = 2'b01; run_access(1'b0, 16'h4455, 8'h00, 8'h11, 3, 1'b0);  // R3
    cfg_ws_hi = 2'b10; run_access(1'b1, 16'h4456, 8'hE1, 8'h00, 4, 1'b0);  // R3
    cfg_ws_hi = 2'b11; run_access(1'b0, 16'hFFFF, 8'h00, 8'h7E, 4, 1'b1);  // R3
  endtask

  task automatic test_sectors();
    cfg_bound = 3'd3; cfg_ws_lo = 2'b00; cfg_ws_hi = 2'b10;
    run_access(1'b0, 16'h5FFF, 8'h00, 8'h21, 2, 1'b0);   // R4 lower
    run_access(1'b1, 16'h6000, 8'h42, 8'h00, 4, 1'b0);   // R4 boundary
    cfg_bound = 3'd7; cfg_ws_lo = 2'b01; cfg_ws_hi = 2'b00;
    run_access(1'b0, 16'hDFFF, 8'h00, 8'h5D, 3, 1'b0);   // R4 lower
    run_access(1'b0, 16'hE000, 8'h00, 8'hA0, 2, 1'b0);   // R4 upper
    cfg_bound = 3'd0; cfg_ws_lo = 2'b11; cfg_ws_hi = 2'b00;
    run_access(1'b1, 16'h0000, 8'h0F, 8'h00, 2, 1'b0);   // R4 all upper
  endtask

  task automatic test_back_to_back();
    cfg_bound = 3'd0; cfg_ws_hi = 2'b00;
    @(negedge clk);
    req_write = 1'b0; req_addr = 16'h2233; mem_byte = 8'h77; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;          // T1
    @(negedge clk); @(negedge clk);            // T2, T3
    @(negedge clk);                            // T4
    check(rsp_valid && rsp_rdata == 8'h77, "R8 first read done", rsp_rdata, 8'h77);
    req_write = 1'b1; req_addr = 16'h9ABC; req_wdata = 8'h5B; req_valid = 1'b1;
    #0.1;
    check(xale == 1'b1 && req_ready, "R8 ale in T4", xale, 1);
    check(xad_oe && xad_out == 8'hBC, "R8 new low addr in T4", xad_out, 8'hBC);
    check(xa_hi == 8'h9A, "R8 new high addr in T4", xa_hi, 8'h9A);
    @(negedge clk); req_valid = 1'b0;
    check(!xwr_n && xad_out == 8'h5B, "R8 strobe follows T4", {xwr_n, xad_out}, 8'h5B);
    @(negedge clk); @(negedge clk);
    check(rsp_valid == 1'b1, "R10 second pulse", rsp_valid, 1);
    @(negedge clk);
  endtask

  task automatic test_keeper();
    cfg_bound = 3'd0; cfg_ws_hi = 2'b00; cfg_keep_en = 1'b1;
    run_access(1'b1, 16'h0310, 8'hA7, 8'h00, 2, 1'b0);
    check(xad_keep && !xad_oe && xad_out == 8'hA7, "R9 keeps write byte", xad_out, 8'hA7);
    @(negedge clk);
    check(xad_keep && xad_out == 8'hA7, "R9 still held", xad_out, 8'hA7);
    cfg_keep_en = 1'b0;
    #0.1 check(xad_keep == 1'b0, "R9 keeper off", xad_keep, 0);
    cfg_keep_en = 1'b1;
    run_access(1'b0, 16'h1234, 8'h00, 8'h66, 2, 1'b0);
    check(xad_keep && xad_out == 8'h34, "R9 keeps address byte", xad_out, 8'h34);
    cfg_keep_en = 1'b0;
  endtask

  initial begin
    #20000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_zero_wait();
    test_codes();
    test_sectors();
    test_back_to_back();
    test_keeper();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule